// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a raw byte window, read from instruction memory at the current program counter, into the fields of one instruction. The first byte carries an operation code in its upper nibble and a function selector in its lower nibble. Depending on the operation, a register byte with two 4-bit register indices may follow, then a little-endian constant. An instruction is therefore 1 to 6 bytes long with the default 4-byte constant.

The decoder checks that each opcode/function pair is legal and reports whether a register byte and a constant are present. It computes the address of the next sequential instruction and forms a 2-bit status from the memory-error flag, the legality result and the halt opcode. The results are registered by default, giving one cycle of latency. A parameter can make the block purely combinational instead.

Top module: `fdec_fetch_decoder`

## Requirements
- R1: While `rst_n` is low, the registered outputs hold a decoded no-op: opcode 1, fncode 0, reg_a and reg_b 0xF, const_val 0, next_pc 0, op_legal 1, has_regbyte 0, has_const 0, status 0.
- R2: opcode is bits [7:4] of window byte 0, and fncode is bits [3:0] of window byte 0. Window byte k occupies `ibytes[8k+7:8k]`.
- R3: The following pairs are legal and every other pair is illegal:
  - opcodes 0 (halt), 1 (no-op), 9 (return), 3, 4, 5, 8, 0xA and 0xB with fncode 0;
  - opcode 6 (arithmetic) with fncode below 4;
  - opcodes 2 (conditional move) and 7 (jump) with fncode below 7.
- R4: has_regbyte is 1 only for legal opcodes 2, 3, 4, 5, 6, 0xA and 0xB. has_const is 1 only for legal opcodes 3, 4, 5, 7 and 8. Both are 0 for an illegal instruction.
- R5: With a register byte present, reg_a is byte 1 bits [7:4] and reg_b is byte 1 bits [3:0]. Without one, both read 0xF, which means no register.
- R6: const_val is assembled little-endian from the 4 bytes that start at byte 2 when a register byte is present, and at byte 1 otherwise. It is 0 when no constant is present.
- R7: next_pc equals pc + 1 + has_regbyte + 4·has_const, taken modulo 2^32, so an illegal instruction gives pc + 1.
- R8: status is 2 (bad address) when imem_err is set. Otherwise it is 3 (bad opcode) for an illegal instruction, 1 (halt) for a legal halt, and 0 (running) for anything else.
- R9: With the default configuration, every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 32 | Address of the window's first byte |
| ibytes | input | 48 | Instruction window, byte 0 in the low bits |
| imem_err | input | 1 | Instruction memory reported an access error |
| opcode | output | 4 | Operation code |
| fncode | output | 4 | Function selector |
| reg_a | output | 4 | First register index, 0xF when absent |
| reg_b | output | 4 | Second register index, 0xF when absent |
| const_val | output | 32 | Embedded constant, 0 when absent |
| next_pc | output | 32 | Fall-through address |
| op_legal | output | 1 | Opcode/function pair is legal |
| has_regbyte | output | 1 | Register byte present |
| has_const | output | 1 | Constant present |
| status | output | 2 | 0 running, 1 halt, 2 bad address, 3 bad opcode |

## Verification
Two status causes can arrive in the same cycle: a memory error and an illegal or halting first byte. The bench forces this collision with a full pass over all 256 first-byte values while imem_err is held high, and every result must read bad address.

A second collision is the longest instruction at the top of the address space, where the fall-through sum wraps. One pass places pc at 0xFFFFFFFE for every first byte and compares next_pc against a length computed from the legality table.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

   localparam logic [3:0] OP_HALT  = 4'h0;
   localparam logic [3:0] OP_NOP   = 4'h1;
   localparam logic [3:0] OP_CMOV  = 4'h2;
   localparam logic [3:0] OP_IRMOV = 4'h3;
   localparam logic [3:0] OP_RMMOV = 4'h4;
   localparam logic [3:0] OP_MRMOV = 4'h5;
   localparam logic [3:0] OP_ALU   = 4'h6;
   localparam logic [3:0] OP_JUMP  = 4'h7;
   localparam logic [3:0] OP_CALL  = 4'h8;
   localparam logic [3:0] OP_RET   = 4'h9;
   localparam logic [3:0] OP_PUSH  = 4'hA;
   localparam logic [3:0] OP_POP   = 4'hB;

   localparam logic [3:0] NO_REG   = 4'hF;

   typedef logic [1:0] stat_t;
   localparam stat_t ST_RUN    = 2'd0;
   localparam stat_t ST_HALT   = 2'd1;
   localparam stat_t ST_BADADR = 2'd2;
   localparam stat_t ST_BADOP  = 2'd3;

   typedef struct packed {
      logic legal;
      logic regbyte;
      logic cnst;
   } op_flags_t;

endpackage

// File: rtl/fdec_classify.sv
module fdec_classify
   import fdec_pkg::*;
#(
   parameter int ALU_OPS    = 4,
   parameter int COND_CODES = 7
) (
   input  logic [3:0] opcode,
   input  logic [3:0] fncode,
   output op_flags_t  flags
);
   localparam logic [4:0] ALU_LIM  = 5'(ALU_OPS);
   localparam logic [4:0] COND_LIM = 5'(COND_CODES);

   if (ALU_OPS < 1 || ALU_OPS > 16)
      $error("fdec_classify: ALU_OPS must be 1..16");
   if (COND_CODES < 1 || COND_CODES > 16)
      $error("fdec_classify: COND_CODES must be 1..16");

   logic       fn_zero;
   logic [4:0] fn_ext;
   op_flags_t  raw;

   assign fn_zero = (fncode == 4'h0);
   assign fn_ext  = {1'b0, fncode};

   always_comb begin
      raw = '0;
      unique case (opcode)
         OP_HALT, OP_NOP, OP_RET: raw.legal = fn_zero;
         OP_CMOV: begin
            raw.legal   = fn_ext < COND_LIM;
            raw.regbyte = 1'b1;
         end
         OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
            raw.legal   = fn_zero;
            raw.regbyte = 1'b1;
            raw.cnst    = 1'b1;
         end
         OP_ALU: begin
            raw.legal   = fn_ext < ALU_LIM;
            raw.regbyte = 1'b1;
         end
         OP_JUMP: begin
            raw.legal = fn_ext < COND_LIM;
            raw.cnst  = 1'b1;
         end
         OP_CALL: begin
            raw.legal = fn_zero;
            raw.cnst  = 1'b1;
         end
         OP_PUSH, OP_POP: begin
            raw.legal   = fn_zero;
            raw.regbyte = 1'b1;
         end
         default: raw = '0;
      endcase
   end

   // an illegal instruction occupies exactly one byte
   always_comb begin
      flags         = raw;
      flags.regbyte = raw.legal & raw.regbyte;
      flags.cnst    = raw.legal & raw.cnst;
   end

endmodule

// File: rtl/fdec_extract.sv
module fdec_extract
   import fdec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int WIN_BYTES  = 2 + WORD_BYTES
) (
   input  logic [ADDR_W-1:0]       pc,
   input  logic [WIN_BYTES*8-1:0]  window,
   input  op_flags_t               flags,
   output logic [3:0]              reg_a,
   output logic [3:0]              reg_b,
   output logic [WORD_BYTES*8-1:0] const_val,
   output logic [ADDR_W-1:0]       next_pc
);
   localparam int CW = WORD_BYTES * 8;

   if (WIN_BYTES != 2 + WORD_BYTES)
      $error("fdec_extract: WIN_BYTES must equal 2 + WORD_BYTES");

   logic [CW-1:0] cbytes;

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
      assign cbytes[k*8 +: 8] = flags.regbyte ? window[(k+2)*8 +: 8]
                                              : window[(k+1)*8 +: 8];
   end

   assign reg_a     = flags.regbyte ? window[15:12] : NO_REG;
   assign reg_b     = flags.regbyte ? window[11:8]  : NO_REG;
   assign const_val = flags.cnst ? cbytes : '0;

   logic [ADDR_W-1:0] len;
   always_comb begin
      len = ADDR_W'(1);
      if (flags.regbyte) len = len + ADDR_W'(1);
      if (flags.cnst)    len = len + ADDR_W'(WORD_BYTES);
   end
   assign next_pc = pc + len;

endmodule

// File: rtl/fdec_status.sv
module fdec_status
   import fdec_pkg::*;
(
   input  logic       imem_err,
   input  logic       legal,
   input  logic [3:0] opcode,
   output stat_t      status
);
   always_comb begin
      if (imem_err)                status = ST_BADADR;
      else if (!legal)             status = ST_BADOP;
      else if (opcode == OP_HALT)  status = ST_HALT;
      else                         status = ST_RUN;
   end
endmodule

// File: rtl/fdec_fetch_decoder.sv
module fdec_fetch_decoder
   import fdec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int ALU_OPS    = 4,
   parameter int COND_CODES = 7,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       pc,
   input  logic [(2+WORD_BYTES)*8-1:0] ibytes,
   input  logic                    imem_err,
   output logic [3:0]              opcode,
   output logic [3:0]              fncode,
   output logic [3:0]              reg_a,
   output logic [3:0]              reg_b,
   output logic [WORD_BYTES*8-1:0] const_val,
   output logic [ADDR_W-1:0]       next_pc,
   output logic                    op_legal,
   output logic                    has_regbyte,
   output logic                    has_const,
   output logic [1:0]              status
);
   localparam int WIN_BYTES = 2 + WORD_BYTES;
   localparam int CW        = WORD_BYTES * 8;

   if (ADDR_W < 8 || ADDR_W > 64)
      $error("fdec_fetch_decoder: ADDR_W must be 8..64");
   if (WORD_BYTES < 1 || WORD_BYTES > 8)
      $error("fdec_fetch_decoder: WORD_BYTES must be 1..8");

   logic [3:0]        d_opc, d_fn, d_ra, d_rb;
   logic [CW-1:0]     d_const;
   logic [ADDR_W-1:0] d_npc;
   op_flags_t         d_flags;
   stat_t             d_stat;

   assign d_opc = ibytes[7:4];
   assign d_fn  = ibytes[3:0];

   fdec_classify #(.ALU_OPS(ALU_OPS), .COND_CODES(COND_CODES)) u_cls (
      .opcode (d_opc),
      .fncode (d_fn),
      .flags  (d_flags)
   );

   fdec_extract #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES)) u_ext (
      .pc        (pc),
      .window    (ibytes),
      .flags     (d_flags),
      .reg_a     (d_ra),
      .reg_b     (d_rb),
      .const_val (d_const),
      .next_pc   (d_npc)
   );

   fdec_status u_st (
      .imem_err (imem_err),
      .legal    (d_flags.legal),
      .opcode   (d_opc),
      .status   (d_stat)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            opcode      <= OP_NOP;
            fncode      <= 4'h0;
            reg_a       <= NO_REG;
            reg_b       <= NO_REG;
            const_val   <= '0;
            next_pc     <= '0;
            op_legal    <= 1'b1;
            has_regbyte <= 1'b0;
            has_const   <= 1'b0;
            status      <= ST_RUN;
         end else begin
            opcode      <= d_opc;
            fncode      <= d_fn;
            reg_a       <= d_ra;
            reg_b       <= d_rb;
            const_val   <= d_const;
            next_pc     <= d_npc;
            op_legal    <= d_flags.legal;
            has_regbyte <= d_flags.regbyte;
            has_const   <= d_flags.cnst;
            status      <= d_stat;
         end
      end
   end else begin : g_comb
      assign opcode      = d_opc;
      assign fncode      = d_fn;
      assign reg_a       = d_ra;
      assign reg_b       = d_rb;
      assign const_val   = d_const;
      assign next_pc     = d_npc;
      assign op_legal    = d_flags.legal;
      assign has_regbyte = d_flags.regbyte;
      assign has_const   = d_flags.cnst;
      assign status      = d_stat;
   end

   p_noreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !has_regbyte |-> (reg_a == NO_REG && reg_b == NO_REG))
      else $error("R5: register ids not 0xF without register byte");

   p_noconst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !has_const |-> (const_val == '0))
      else $error("R6: constant nonzero while absent");

   p_illegal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !op_legal |-> (!has_regbyte && !has_const))
      else $error("R4: illegal instruction with extra bytes");

   p_illegal_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !op_legal |-> (status == ST_BADOP || status == ST_BADADR))
      else $error("R8: illegal instruction with running status");

   p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_HALT) |-> (opcode == OP_HALT && op_legal))
      else $error("R8: halt status from non-halt instruction");

   p_regout_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && $past(rst_n) && $past(imem_err)) |-> (status == ST_BADADR))
      else $error("R9: memory error not visible one cycle later");

endmodule

// File: tb/sim_fdec_fetch_decoder.sv
module sim_fdec_fetch_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc = '0;
   logic [47:0] ibytes = '0;
   logic        imem_err = 1'b0;
   logic [3:0]  opcode, fncode, reg_a, reg_b;
   logic [31:0] const_val, next_pc;
   logic        op_legal, has_regbyte, has_const;
   logic [1:0]  status;

   int total = 0;
   int bad   = 0;
   logic [31:0] lfsr = 32'hACE1_2357;

   always #5 clk = ~clk;

   fdec_fetch_decoder u0 (
      .clk(clk), .rst_n(rst_n), .pc(pc), .ibytes(ibytes), .imem_err(imem_err),
      .opcode(opcode), .fncode(fncode), .reg_a(reg_a), .reg_b(reg_b),
      .const_val(const_val), .next_pc(next_pc), .op_legal(op_legal),
      .has_regbyte(has_regbyte), .has_const(has_const), .status(status)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   task automatic run_vec(input logic [31:0] p, input logic [47:0] w, input logic err);
      logic [3:0]  op, fn;
      logic        lg, rb, cs;
      logic [31:0] ec, enp;
      logic [1:0]  es;
      @(negedge clk);
      pc = p; ibytes = w; imem_err = err;
      op = w[7:4]; fn = w[3:0];
      case (op)
         4'h0, 4'h1, 4'h9, 4'h3, 4'h4, 4'h5, 4'h8, 4'hA, 4'hB: lg = (fn == 0);
         4'h6:       lg = (fn < 4);
         4'h2, 4'h7: lg = (fn < 7);
         default:    lg = 1'b0;
      endcase
      rb = lg && (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
      cs = lg && (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
      ec  = !cs ? 32'h0 : (rb ? w[47:16] : w[39:8]);
      enp = p + 32'd1 + (rb ? 32'd1 : 32'd0) + (cs ? 32'd4 : 32'd0);
      es  = err ? 2'd2 : (!lg ? 2'd3 : (op == 4'h0 ? 2'd1 : 2'd0));
      // R9: outputs appear after one rising edge
      @(negedge clk);
      chk("R2 opcode", 64'(opcode), 64'(op));
      chk("R2 fncode", 64'(fncode), 64'(fn));
      chk("R3 legal", 64'(op_legal), 64'(lg));
      chk("R4 flags", 64'({has_regbyte, has_const}), 64'({rb, cs}));
      chk("R5 regs", 64'({reg_a, reg_b}), rb ? 64'(w[15:8]) : 64'h0FF);
      chk("R6 const", 64'(const_val), 64'(ec));
      chk("R7 next_pc", 64'(next_pc), 64'(enp));
      chk("R8 status", 64'(status), 64'(es));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 opcode", 64'(opcode), 64'h1);
      chk("R1 fncode", 64'(fncode), 64'h0);
      chk("R1 regs", 64'({reg_a, reg_b}), 64'hFF);
      chk("R1 const", 64'(const_val), 64'h0);
      chk("R1 next_pc", 64'(next_pc), 64'h0);
      chk("R1 flags", 64'({op_legal, has_regbyte, has_const}), 64'b100);
      chk("R1 status", 64'(status), 64'h0);
      rst_n = 1'b1;
      for (int pass = 0; pass < 4; pass++) begin
         for (int b = 0; b < 256; b++) begin
            logic [31:0] p;
            step_lfsr();
            p = (pass == 0) ? 32'h0000_0100 :
                (pass == 1) ? 32'hFFFF_FFFE : lfsr;
            step_lfsr();
            run_vec(p, {lfsr, lfsr[15:8] ^ 8'h5A, 8'(b)}, pass == 3);
         end
      end
      // R8 halt with and without memory error, R7 wrap at top of space
      run_vec(32'hFFFF_FFFF, 48'h0, 1'b0);
      run_vec(32'hFFFF_FFFF, 48'h0, 1'b1);
      run_vec(32'hFFFF_FFFC, 48'h7856_3412_F130, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule